// File: doc/BRIEF.md
# Debug Memory Port Address Sequencer

This block sits behind the register interface of a debug memory access port. It holds the transfer address and a control/status word. The control/status word selects the access size and the address-increment mode, and it carries a sticky error flag. A debugger reads and writes these registers one at a time through a simple request/response port. A request to the main data window, or to one of the four banked data windows, becomes a single bus request towards system memory.

The main data window uses the transfer address as the bus address. After the access succeeds, it may advance that address. An advance only moves the low 10 address bits, so the address wraps inside its 1 KiB block. A banked window addresses one of four consecutive words within the 16-byte slot selected by the transfer address, and it never moves the transfer address. Bus errors are recorded in the sticky flag. Software clears that flag by writing a one to it.

Only one register access is in progress at a time. While a bus request is outstanding, the register port is not ready.

Top module: `memap_addr_seq`

## Requirements
- R1: After reset the transfer address reads 0. The control/status word reads 0x00000002: size word, increment off, error clear.
- R2: Register select 1 is the transfer address and reads back the last value written. Select 3 is unmapped: it reads 0 and ignores writes.
- R3: Select 2 is the main data window. An access through it issues one bus request with address equal to the transfer address, the size from control/status bits [1:0] (0 byte, 1 halfword, 2 word, 3 treated as word) and the request's write flag. The write data is carried with the request, and on success read data is returned on the response.
- R4: With the increment field (control/status bits [5:4]) at 0 (off) or 3 (reserved), a main-window access leaves the transfer address unchanged.
- R5: With the increment field at 1 (single), a successful main-window access advances the transfer address by 1, 2 or 4 bytes for byte, halfword or word size.
- R6: Increment field 2 (packed) advances the transfer address exactly as single does.
- R7: An advance changes only address bits [9:0]. A carry out of bit 9 is dropped, so the address wraps inside its 1 KiB block.
- R8: Selects 4 to 7 are banked windows 0 to 3. Banked window n uses bus address {TAR[31:4], n[1:0], 2'b00}, and it never changes the transfer address, whatever the increment mode.
- R9: Changing the increment mode between accesses keeps the address that earlier advancing accesses produced. A read of the transfer address always equals the address the next main-window access will use.
- R10: A bus error response sets the sticky error flag (control/status bit 7) and returns rsp_err=1 with read data 0. It leaves the transfer address unchanged for the failed access, for both main and banked windows.
- R11: A control/status write with bit 7 set clears the error flag. A write with bit 7 clear leaves the flag as it was.
- R12: While a bus request is outstanding, req_ready is 0. bus_valid and bus_addr hold steady until bus_done, and the response follows one cycle after bus_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_ready | output | 1 | Port can accept a request this cycle |
| req_sel | input | 3 | Register select: 0 control/status, 1 address, 2 main window, 4-7 banked windows |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 32 | Read data of the response |
| rsp_err | output | 1 | Response reports a bus error |
| bus_valid | output | 1 | Bus request outstanding |
| bus_addr | output | 32 | Bus byte address |
| bus_size | output | 2 | Access size code |
| bus_write | output | 1 | Bus write flag |
| bus_wdata | output | 32 | Bus write data |
| bus_done | input | 1 | Bus request completes this cycle |
| bus_err | input | 1 | Completion carries an error |
| bus_rdata | input | 32 | Bus read data |

## Verification
The bench targets the block-boundary wrap. A design that carried the increment into bit 10 would show a changed upper address after an access at 0x...03FC. It mixes banked and main-window accesses while auto-increment is on, which exposes a design that advances the address on banked accesses or builds the banked slot from the wrong bits. It switches the increment mode off and on between accesses, to catch a design whose read-back address falls out of step with the true next address. It also injects bus errors, to show that a failing access neither moves the address nor loses the sticky flag except when bit 7 is written as one.

// File: rtl/memap_pkg.sv
package memap_pkg;

    localparam int SEL_W = 3;

    localparam logic [SEL_W-1:0] SEL_CSW  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_TAR  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_MAIN = 3'd2;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        INC_OFF    = 2'd0,
        INC_SINGLE = 2'd1,
        INC_PACKED = 2'd2,
        INC_RSVD   = 2'd3
    } inc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } state_e;

endpackage

// File: rtl/memap_tar_step.sv
module memap_tar_step
    import memap_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int BLOCK_BITS = 10
) (
    input  logic [ADDR_W-1:0] tar_i,
    input  size_e             size_i,
    output logic [ADDR_W-1:0] tar_o
);
    logic [BLOCK_BITS-1:0] step;
    logic [BLOCK_BITS-1:0] low_sum;

    always_comb begin
        case (size_i)
            SZ_BYTE: step = BLOCK_BITS'(1);
            SZ_HALF: step = BLOCK_BITS'(2);
            default: step = BLOCK_BITS'(4);
        endcase
        low_sum = tar_i[BLOCK_BITS-1:0] + step;
    end

    generate
        if (BLOCK_BITS < ADDR_W) begin : g_upper
            assign tar_o = {tar_i[ADDR_W-1:BLOCK_BITS], low_sum};
        end else begin : g_full
            assign tar_o = low_sum;
        end
    endgenerate
endmodule

// File: rtl/memap_bank_addr.sv
module memap_bank_addr #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] tar_i,
    input  logic              banked_i,
    input  logic [1:0]        bank_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] slot_addr;

    assign slot_addr = {tar_i[ADDR_W-1:4], bank_i, 2'b00};

    always_comb begin
        addr_o = banked_i ? slot_addr : tar_i;
    end
endmodule

// File: rtl/memap_addr_seq.sv
module memap_addr_seq
    import memap_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int BLOCK_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_sel,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [1:0]        bus_size,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_done,
    input  logic              bus_err,
    input  logic [DATA_W-1:0] bus_rdata
);
    localparam int ERR_BIT = 7;

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] tar;
        size_e             size;
        inc_e              inc;
        logic              err;
        logic              main;
        logic [ADDR_W-1:0] baddr;
        logic              bwrite;
        logic [DATA_W-1:0] bwdata;
        logic              rsp_v;
        logic              rsp_e;
        logic [DATA_W-1:0] rsp_d;
    } regs_t;

    regs_t q, d;

    logic              accept;
    logic              is_bank;
    logic              is_window;
    logic [ADDR_W-1:0] tar_adv;
    logic [ADDR_W-1:0] issue_addr;
    logic [DATA_W-1:0] csw_word;
    logic              completing;

    memap_tar_step #(
        .ADDR_W    (ADDR_W),
        .BLOCK_BITS(BLOCK_BITS)
    ) u_step (
        .tar_i (q.tar),
        .size_i(q.size),
        .tar_o (tar_adv)
    );

    memap_bank_addr #(
        .ADDR_W(ADDR_W)
    ) u_bank (
        .tar_i   (q.tar),
        .banked_i(is_bank),
        .bank_i  (req_sel[1:0]),
        .addr_o  (issue_addr)
    );

    assign accept     = (q.st == ST_IDLE) && req_valid;
    assign is_bank    = req_sel[2];
    assign is_window  = is_bank || (req_sel == SEL_MAIN);
    assign completing = (q.st == ST_BUS) && bus_done;
    assign csw_word   = DATA_W'({q.err, 1'b0, q.inc, 2'b00, q.size});

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;
        d.rsp_e = 1'b0;
        d.rsp_d = '0;
        if (accept) begin
            if (is_window) begin
                d.st     = ST_BUS;
                d.main   = !is_bank;
                d.baddr  = issue_addr;
                d.bwrite = req_write;
                d.bwdata = req_write ? req_wdata : '0;
            end else begin
                d.rsp_v = 1'b1;
                if (req_sel == SEL_CSW) begin
                    if (req_write) begin
                        d.size = size_e'(req_wdata[1:0]);
                        d.inc  = inc_e'(req_wdata[5:4]);
                        if (req_wdata[ERR_BIT]) begin
                            d.err = 1'b0;
                        end
                    end else begin
                        d.rsp_d = csw_word;
                    end
                end else if (req_sel == SEL_TAR) begin
                    if (req_write) begin
                        d.tar = req_wdata[ADDR_W-1:0];
                    end else begin
                        d.rsp_d = DATA_W'(q.tar);
                    end
                end
            end
        end
        if (completing) begin
            d.st    = ST_IDLE;
            d.rsp_v = 1'b1;
            if (bus_err) begin
                d.err   = 1'b1;
                d.rsp_e = 1'b1;
            end else begin
                if (!q.bwrite) begin
                    d.rsp_d = bus_rdata;
                end
                if (q.main && (q.inc == INC_SINGLE || q.inc == INC_PACKED)) begin
                    d.tar = tar_adv;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.size   <= SZ_WORD;
            q.inc    <= INC_OFF;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == ST_IDLE);
    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rsp_d;
    assign rsp_err   = q.rsp_e;
    assign bus_valid = (q.st == ST_BUS);
    assign bus_addr  = q.baddr;
    assign bus_size  = q.size;
    assign bus_write = q.bwrite;
    assign bus_wdata = q.bwdata;

    // R3
    main_issue_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && req_sel == SEL_MAIN) |=> (bus_valid && bus_addr == $past(q.tar)));

    // R7
    block_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (completing && q.main) |=> (q.tar[ADDR_W-1:BLOCK_BITS] == $past(q.tar[ADDR_W-1:BLOCK_BITS])));

    // R8
    bank_keeps_tar_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (completing && !q.main) |=> $stable(q.tar));

    // R10
    err_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (completing && bus_err) |=> (q.err && rsp_err && $stable(q.tar)));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.err && !(accept && req_write && req_sel == SEL_CSW && req_wdata[ERR_BIT])) |=> q.err);

    // R12
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_done) |=> (bus_valid && $stable(bus_addr) && !req_ready));

    // R12
    rsp_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        completing |=> (rsp_valid && !bus_valid));
endmodule

// File: tb/memap_addr_seq_bench.sv
module memap_addr_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_sel = '0;
    logic        req_write = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [1:0]  bus_size;
    logic        bus_write;
    logic [31:0] bus_wdata;
    logic        bus_done = 1'b0;
    logic        bus_err = 1'b0;
    logic [31:0] bus_rdata = '0;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [31:0] m_tar = 32'h0;
    logic [1:0]  m_size = 2'd2;
    logic [1:0]  m_inc = 2'd0;
    logic        m_err = 1'b0;
    logic        exp_busy = 1'b0;
    logic [31:0] exp_addr = 32'h0;

    memap_addr_seq u_memap_addr_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_sel(req_sel),
        .req_write(req_write), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_size(bus_size),
        .bus_write(bus_write), .bus_wdata(bus_wdata),
        .bus_done(bus_done), .bus_err(bus_err), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_fn(input logic [31:0] a);
        return a ^ 32'hC3C3_0000;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model (R12, R3)
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            check("R12 ready", {31'b0, req_ready}, {31'b0, !exp_busy});
            check("R12 bus_valid", {31'b0, bus_valid}, {31'b0, exp_busy});
            if (exp_busy) check("R3 bus_addr", bus_addr, exp_addr);
        end
    end

    task automatic advance_model();
        int step;
        int low;
        step = (m_size == 2'd0) ? 1 : (m_size == 2'd1) ? 2 : 4;
        low = (int'(m_tar) & 1023) + step;
        low = low % 1024;
        m_tar = (m_tar & 32'hFFFF_FC00) | 32'(low);
    endtask

    task automatic xfer(input logic [2:0] sel, input logic wr, input logic [31:0] wd,
                        input logic berr, input int lat, input string tag);
        logic        win;
        logic [31:0] exp_r;
        logic [31:0] eff_size;
        win = sel[2] || (sel == 3'd2);
        exp_r = 32'h0;
        @(negedge clk);
        req_valid = 1'b1; req_sel = sel; req_write = wr; req_wdata = wd;
        if (win) begin
            exp_busy = 1'b1;
            exp_addr = sel[2] ? {m_tar[31:4], sel[1:0], 2'b00} : m_tar;
        end else if (!wr) begin
            if (sel == 3'd0) exp_r = {24'b0, m_err, 1'b0, m_inc, 2'b00, m_size};
            else if (sel == 3'd1) exp_r = m_tar;
        end
        @(negedge clk);
        req_valid = 1'b0;
        if (win) begin
            eff_size = {30'b0, m_size};
            check({tag, " R3 size"}, {30'b0, bus_size}, eff_size);
            check({tag, " R3 write"}, {31'b0, bus_write}, {31'b0, wr});
            if (wr) check({tag, " R3 wdata"}, bus_wdata, wd);
            repeat (lat) @(negedge clk);
            bus_done = 1'b1; bus_err = berr; bus_rdata = mem_fn(exp_addr);
            exp_busy = 1'b0;
            if (!wr && !berr) exp_r = mem_fn(exp_addr);
            @(negedge clk);
            bus_done = 1'b0; bus_err = 1'b0;
            if (berr) m_err = 1'b1;
            else if (sel == 3'd2 && (m_inc == 2'd1 || m_inc == 2'd2)) advance_model();
        end else if (wr) begin
            if (sel == 3'd0) begin
                m_size = wd[1:0]; m_inc = wd[5:4];
                if (wd[7]) m_err = 1'b0;
            end else if (sel == 3'd1) begin
                m_tar = wd;
            end
        end
        check({tag, " rsp_valid"}, {31'b0, rsp_valid}, 32'd1);
        check({tag, " rsp_err"}, {31'b0, rsp_err}, {31'b0, win && berr});
        if (!wr || (win && berr)) check({tag, " rdata"}, rsp_rdata, exp_r);
    endtask

    task automatic rd(input logic [2:0] sel, input string tag);
        xfer(sel, 1'b0, 32'h0, 1'b0, 0, tag);
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] v, input string tag);
        xfer(sel, 1'b1, v, 1'b0, 0, tag);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset values
        rd(3'd0, "R1 csw");
        rd(3'd1, "R1 tar");
        // R2 address register and unmapped select
        wr(3'd1, 32'h2000_0100, "R2");
        rd(3'd1, "R2 tar");
        wr(3'd3, 32'hFFFF_FFFF, "R2 unmapped");
        rd(3'd3, "R2 unmapped");
        rd(3'd1, "R2 tar kept");
        // R3/R4 main window, increment off and reserved
        wr(3'd0, 32'h0000_0002, "R4");
        xfer(3'd2, 1'b1, 32'hDEAD_BEEF, 1'b0, 2, "R3 write");
        rd(3'd2, "R3 read");
        rd(3'd1, "R4 tar");
        wr(3'd0, 32'h0000_0032, "R4 rsvd");
        rd(3'd2, "R4 rsvd read");
        rd(3'd1, "R4 rsvd tar");
        // R5 single increment per size
        wr(3'd0, 32'h0000_0010, "R5 byte");
        for (int i = 0; i < 3; i++) rd(3'd2, "R5 byte");
        rd(3'd1, "R5 tar byte");
        wr(3'd0, 32'h0000_0011, "R5 half");
        for (int i = 0; i < 2; i++) rd(3'd2, "R5 half");
        rd(3'd1, "R5 tar half");
        wr(3'd0, 32'h0000_0013, "R5 rsvd size");
        rd(3'd2, "R5 rsvd size");
        rd(3'd1, "R5 tar word");
        // R6 packed
        wr(3'd0, 32'h0000_0022, "R6");
        for (int i = 0; i < 2; i++) rd(3'd2, "R6");
        rd(3'd1, "R6 tar");
        // R7 wrap at block boundary
        wr(3'd1, 32'h1234_03FC, "R7");
        wr(3'd0, 32'h0000_0012, "R7");
        rd(3'd2, "R7 word");
        rd(3'd1, "R7 tar wrapped");
        wr(3'd1, 32'h5678_FFFF, "R7 byte");
        wr(3'd0, 32'h0000_0010, "R7 byte");
        xfer(3'd2, 1'b1, 32'h0000_00AB, 1'b0, 1, "R7 byte");
        rd(3'd1, "R7 tar byte wrapped");
        // R8 banked windows with increment on
        wr(3'd1, 32'h4000_1238, "R8");
        wr(3'd0, 32'h0000_0012, "R8");
        for (int i = 4; i < 8; i++) rd(3'(i), "R8 bank");
        xfer(3'd6, 1'b1, 32'h1111_2222, 1'b0, 0, "R8 bank write");
        rd(3'd1, "R8 tar kept");
        rd(3'd2, "R8 main after banks");
        rd(3'd5, "R8 bank after advance");
        // R9 mode switch keeps advanced address
        rd(3'd2, "R9");
        wr(3'd0, 32'h0000_0002, "R9 off");
        rd(3'd1, "R9 tar");
        rd(3'd2, "R9 main off");
        wr(3'd0, 32'h0000_0022, "R9 packed");
        rd(3'd2, "R9 main packed");
        rd(3'd1, "R9 tar after");
        // R10 bus errors
        xfer(3'd2, 1'b0, 32'h0, 1'b1, 1, "R10 main err");
        rd(3'd1, "R10 tar kept");
        rd(3'd0, "R10 csw err");
        xfer(3'd7, 1'b1, 32'h5555_AAAA, 1'b1, 0, "R10 bank err");
        rd(3'd1, "R10 tar kept bank");
        // R11 clear rules
        wr(3'd0, 32'h0000_0022, "R11 no clear");
        rd(3'd0, "R11 still set");
        rd(3'd2, "R11 ok access");
        rd(3'd0, "R11 still set after ok");
        wr(3'd0, 32'h0000_00A2, "R11 clear");
        rd(3'd0, "R11 cleared");
        // R12 long latency
        xfer(3'd2, 1'b0, 32'h0, 1'b0, 6, "R12 slow");
        rd(3'd1, "R12 tar");
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule